// File: doc/BRIEF.md
# Narrowing Fixed-Point Clip Unit

This block takes one double-width integer element and produces a single-width element. It right-shifts the element, adds a rounding increment chosen by a 2-bit rounding mode, and clamps the sum to the range of the narrow destination. It handles destination widths of 8, 16 and 32 bits, fed from sources of 16, 32 and 64 bits. It works in a signed or an unsigned interpretation.

A small decoder inside the block inspects the 32-bit instruction word. From that word it takes the signedness and the source of the shift amount: a vector element, a scalar register value or a 5-bit immediate. The result is registered, so it appears one clock after a valid input is presented.

Whenever a value had to be clamped, a sticky saturation flag is set. It stays set until a synchronous clear input is driven. Register access, masking and element sequencing sit outside the block.

Top module: `nclip_unit`

## Requirements
- R1: An input is accepted only when instr[6:0] is 1010111, instr[31:26] is 101110 (unsigned) or 101111 (signed), instr[14:12] is 000, 100 or 011, and width_sel is not 3. Any other valid input raises `illegal` for one cycle without `out_valid` and without touching the saturation flag.
- R2: The raw shift operand is chosen by instr[14:12]. Code 000 takes `vec_opnd`, 100 takes `scalar_opnd`, and 011 takes instr[19:15] zero-extended, in both signed and unsigned mode.
- R3: width_sel 0, 1 and 2 select 8, 16 and 32-bit results. Only the low 4, 5 or 6 bits of the raw shift operand are used, respectively.
- R4: The source is the low 16, 32 or 64 bits of `wide_src`. It is shifted arithmetically in signed mode and logically in unsigned mode.
- R5: The rounding increment is 0 for a zero shift. Otherwise, with d the highest bit shifted out, r the OR of the lower shifted-out bits and l the LSB of the shifted value, it is as follows. rnd_mode 00 (nearest-up) gives d. 01 (nearest-even) gives d&(r|l). 10 (truncate) gives 0. 11 (jam to odd) gives !l&(d|r).
- R6: In signed mode, a rounded value above 2^(N-1)-1 becomes 2^(N-1)-1, and a value below -2^(N-1) becomes -2^(N-1).
- R7: In unsigned mode, a rounded value above 2^N-1 becomes 2^N-1. This includes a carry caused by the rounding increment.
- R8: `sat_flag` is set one cycle after an accepted input that clamped. It is never cleared by an operation. It is cleared one cycle after `sat_clr`, and the clear wins over a clamp in the same cycle.
- R9: `result` and `out_valid` appear one cycle after the accepted input. `result` holds the N-bit value in its low bits with the upper bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input element and instruction are present |
| instr | input | 32 | Instruction word to decode |
| vec_opnd | input | 64 | Shift operand from a vector element |
| scalar_opnd | input | 64 | Shift operand from a scalar register |
| wide_src | input | 64 | Double-width source element |
| width_sel | input | 2 | Destination width: 0=8, 1=16, 2=32 |
| rnd_mode | input | 2 | Rounding mode |
| sat_clr | input | 1 | Synchronous clear of the saturation flag |
| out_valid | output | 1 | Result valid |
| illegal | output | 1 | Valid input failed decode |
| result | output | 32 | Narrowed, rounded, clamped element |
| sat_flag | output | 1 | Sticky saturation flag |

## Verification
The hardest case to reach is a carry into the bit above the unsigned maximum that is caused only by the rounding increment. Without that carry, the shifted value itself still fits. The bench reaches this by picking a source whose shifted value is exactly all-ones and whose highest shifted-out bit is set, under nearest-up rounding.

A second hard case is a clear and a clamp landing in the same cycle. The bench drives `sat_clr` together with a saturating input.

// File: rtl/nclip_unit.sv
module nclip_unit #(
  parameter int DMAX = 32,
  localparam int SMAX = 2 * DMAX,
  localparam int AW = SMAX + 2,
  localparam int SHW = $clog2(SMAX)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [31:0]     instr,
  input  logic [SMAX-1:0] vec_opnd,
  input  logic [SMAX-1:0] scalar_opnd,
  input  logic [SMAX-1:0] wide_src,
  input  logic [1:0]      width_sel,
  input  logic [1:0]      rnd_mode,
  input  logic            sat_clr,
  output logic            out_valid,
  output logic            illegal,
  output logic [DMAX-1:0] result,
  output logic            sat_flag
);
  logic [2:0] f3;
  logic is_op, signed_md, legal, fire;
  assign f3 = instr[14:12];
  assign is_op = (instr[6:0] == 7'b1010111) && (instr[31:27] == 5'b10111);
  assign signed_md = instr[26];
  assign legal = is_op && (f3 == 3'b000 || f3 == 3'b100 || f3 == 3'b011) && (width_sel != 2'd3);
  assign fire = in_valid && legal;

  logic [SMAX-1:0] shift_opnd;
  always_comb begin
    case (f3)
      3'b000:  shift_opnd = vec_opnd;
      3'b100:  shift_opnd = scalar_opnd;
      default: shift_opnd = {{(SMAX-5){1'b0}}, instr[19:15]};
    endcase
  end

  logic [SHW-1:0] sh;
  logic [7:0] sw, sew;
  always_comb begin
    case (width_sel)
      2'd0:    begin sw = 8'd16; sew = 8'd8;  sh = shift_opnd[SHW-1:0] & SHW'(15); end
      2'd1:    begin sw = 8'd32; sew = 8'd16; sh = shift_opnd[SHW-1:0] & SHW'(31); end
      default: begin sw = 8'd64; sew = 8'd32; sh = shift_opnd[SHW-1:0] & SHW'(63); end
    endcase
  end

  logic sbit;
  logic [AW-1:0] src_ext;
  assign sbit = signed_md & wide_src[sw-8'd1];
  always_comb begin
    for (int i = 0; i < AW; i++)
      src_ext[i] = (i < int'(sw)) ? wide_src[i] : sbit;
  end

  logic signed [AW-1:0] shifted, sum, smax, smin, umax, clamped;
  logic [AW-1:0] low_mask, half_mask;
  logic d, rest, lsb, inc, clip;
  assign shifted   = $signed(src_ext) >>> sh;
  assign low_mask  = (AW'(1) << sh) - AW'(1);
  assign half_mask = low_mask >> 1;
  assign d    = |(src_ext & (low_mask ^ half_mask));
  assign rest = |(src_ext & half_mask);
  assign lsb  = shifted[0];

  always_comb begin
    case (rnd_mode)
      2'b00:   inc = d;
      2'b01:   inc = d & (rest | lsb);
      2'b10:   inc = 1'b0;
      default: inc = ~lsb & (d | rest);
    endcase
  end

  assign sum  = shifted + {{(AW-1){1'b0}}, inc};
  assign umax = (AW'(1) << sew) - AW'(1);
  assign smax = (AW'(1) << (sew - 8'd1)) - AW'(1);
  assign smin = ~smax;

  always_comb begin
    clip = 1'b1;
    if (signed_md && sum > smax)       clamped = smax;
    else if (signed_md && sum < smin)  clamped = smin;
    else if (!signed_md && sum > umax) clamped = umax;
    else begin clamped = sum; clip = 1'b0; end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      illegal   <= 1'b0;
      result    <= '0;
      sat_flag  <= 1'b0;
    end else begin
      out_valid <= fire;
      illegal   <= in_valid && !legal;
      if (fire) result <= clamped[DMAX-1:0] & umax[DMAX-1:0];
      if (sat_clr) sat_flag <= 1'b0;
      else if (fire && clip) sat_flag <= 1'b1;
    end
  end
endmodule

// File: rtl/nclip_unit_chk.sv
module nclip_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        sat_clr,
  input logic [1:0]  width_sel,
  input logic        out_valid,
  input logic        illegal,
  input logic [31:0] result,
  input logic        sat_flag
);
  p_valid_needs_input_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));
  p_accept_or_reject_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && illegal));
  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_flag && !sat_clr) |=> sat_flag);
  p_flag_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sat_clr |=> !sat_flag);
  p_flag_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sat_flag) |-> ($past(in_valid) && !$past(sat_clr)));
  p_upper_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(width_sel) == 2'd0) |-> (result[31:8] == 24'd0));
endmodule

bind nclip_unit nclip_unit_chk u_chk (.*);

// File: tb/nclip_unit_test.sv
module nclip_unit_test;
  localparam int PERIOD = 10;
  logic clk = 0, rst_n = 0, in_valid = 0, sat_clr = 0;
  logic [31:0] instr = 0;
  logic [63:0] vec_opnd = 0, scalar_opnd = 0, wide_src = 0;
  logic [1:0] width_sel = 0, rnd_mode = 0;
  logic out_valid, illegal, sat_flag;
  logic [31:0] result;
  int total = 0, bad = 0;
  bit exp_flag = 0;

  always #(PERIOD/2) clk = ~clk;

  nclip_unit uut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
    .vec_opnd(vec_opnd), .scalar_opnd(scalar_opnd), .wide_src(wide_src),
    .width_sel(width_sel), .rnd_mode(rnd_mode), .sat_clr(sat_clr),
    .out_valid(out_valid), .illegal(illegal), .result(result), .sat_flag(sat_flag));

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(bit sg, logic [2:0] f3, logic [4:0] imm);
    return {5'b10111, sg, 1'b1, 5'd8, imm, f3, 5'd4, 7'b1010111};
  endfunction

  function automatic void ref_clip(int w, bit sg, logic [63:0] src, logic [63:0] opnd,
                                   logic [1:0] rm, output logic [31:0] r, output bit sat);
    int sew = 8 << w;
    int sh = int'(opnd[5:0]) & ((16 << w) - 1);
    logic signed [127:0] v, q, s, mx, mn;
    bit d, rest, lsb, inc;
    v = 0;
    for (int i = 0; i < 128; i++)
      v[i] = (i < 2*sew) ? src[i] : (sg & src[2*sew-1]);
    q = v >>> sh;
    inc = 0;
    if (sh != 0) begin
      d = v[sh-1]; rest = 0; lsb = q[0];
      for (int i = 0; i < sh - 1; i++) rest |= v[i];
      case (rm)
        2'b00: inc = d;
        2'b01: inc = d & (rest | lsb);
        2'b10: inc = 0;
        default: inc = !lsb & (d | rest);
      endcase
    end
    s = q + inc;
    if (sg) begin mx = (128'sd1 <<< (sew-1)) - 1; mn = -mx - 1; end
    else begin mx = (128'sd1 <<< sew) - 1; mn = 0; end
    sat = 1;
    if (s > mx) s = mx;
    else if (s < mn) s = mn;
    else sat = 0;
    r = 32'(s[63:0] & ((64'd1 << sew) - 1));
  endfunction

  task automatic run(string tag, bit sg, logic [2:0] f3, logic [4:0] imm, logic [63:0] vop,
                     logic [63:0] sop, logic [63:0] src, int w, logic [1:0] rm);
    logic [31:0] er; bit es; logic [63:0] op;
    op = (f3 == 3'b000) ? vop : (f3 == 3'b100) ? sop : {59'd0, imm};
    ref_clip(w, sg, src, op, rm, er, es);
    exp_flag |= es;
    @(negedge clk);
    instr = mk(sg, f3, imm); vec_opnd = vop; scalar_opnd = sop; wide_src = src;
    width_sel = 2'(w); rnd_mode = rm; in_valid = 1;
    @(negedge clk);
    in_valid = 0;
    check({tag, " valid"}, {63'd0, out_valid}, 64'd1);
    check({tag, " result"}, {32'd0, result}, {32'd0, er});
    check({tag, " flag"}, {63'd0, sat_flag}, {63'd0, exp_flag});
  endtask

  task automatic clear_flag();
    @(negedge clk); sat_clr = 1;
    @(negedge clk); sat_clr = 0; exp_flag = 0;
    check("R8 clear", {63'd0, sat_flag}, 64'd0);
  endtask

  task automatic t_reset();
    check("R9 reset valid", {63'd0, out_valid}, 64'd0);
    check("R9 reset result", {32'd0, result}, 64'd0);
    check("R8 reset flag", {63'd0, sat_flag}, 64'd0);
  endtask

  task automatic t_shift_modes();
    run("R4 uns", 0, 3'b000, 0, 64'd4, 0, 64'h0AB0, 0, 2'b10);
    check("R4 uns value", {32'd0, result}, 64'hAB);
    run("R4 sgn", 1, 3'b000, 0, 64'd1, 0, 64'hFF80, 0, 2'b10);
    check("R4 sgn value", {32'd0, result}, 64'hC0);
    run("R4 sgn16", 1, 3'b100, 0, 0, 64'd8, 64'hFFFF_8000, 1, 2'b00);
  endtask

  task automatic t_rounding();
    logic [7:0] e6 [4] = '{8'd2, 8'd2, 8'd1, 8'd1};
    logic [7:0] ea [4] = '{8'd3, 8'd2, 8'd2, 8'd3};
    for (int m = 0; m < 4; m++) begin
      run("R5 1.5", 0, 3'b000, 0, 64'd2, 0, 64'h0006, 0, 2'(m));
      check("R5 1.5 value", {32'd0, result}, {56'd0, e6[m]});
      run("R5 2.5", 0, 3'b000, 0, 64'd2, 0, 64'h000A, 0, 2'(m));
      check("R5 2.5 value", {32'd0, result}, {56'd0, ea[m]});
      run("R5 sgn32", 1, 3'b000, 0, 64'd7, 0, 64'hFFFF_FFF0_1234_56C3, 2, 2'(m));
    end
    run("R5 zero shift", 0, 3'b100, 0, 0, 64'd0, 64'h00FF, 0, 2'b11);
  endtask

  task automatic t_mask();
    run("R3 mask8", 0, 3'b000, 0, 64'h14, 0, 64'h0A50, 0, 2'b10);
    check("R3 mask8 value", {32'd0, result}, 64'hA5);
    run("R3 mask16", 0, 3'b100, 0, 0, 64'hE5, 64'h0012_3440, 1, 2'b10);
    run("R3 mask32", 1, 3'b000, 0, 64'hFFC4, 0, 64'h1234_5678_9ABC_DEF0, 2, 2'b01);
  endtask

  task automatic t_imm();
    run("R2 imm sgn", 1, 3'b011, 5'd31, 64'd0, 64'd0, 64'hC000_0000_0000_0000, 2, 2'b00);
    check("R2 imm sgn value", {32'd0, result}, 64'h8000_0000);
    run("R2 scalar", 0, 3'b100, 5'd0, 64'd0, 64'd3, 64'h0000_0040, 1, 2'b10);
    check("R2 scalar value", {32'd0, result}, 64'h8);
  endtask

  task automatic t_saturation();
    clear_flag();
    run("R7 carry", 0, 3'b000, 0, 64'd1, 0, 64'h01FF, 0, 2'b00);
    check("R7 carry value", {32'd0, result}, 64'hFF);
    check("R7 carry flag", {63'd0, sat_flag}, 64'd1);
    clear_flag();
    run("R7 big", 0, 3'b000, 0, 64'd0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 2, 2'b00);
    check("R7 big value", {32'd0, result}, 64'hFFFF_FFFF);
    clear_flag();
    run("R6 high", 1, 3'b000, 0, 64'd0, 0, 64'h0000_7FFF, 1, 2'b10);
    check("R6 high value", {32'd0, result}, 64'h7FFF);
    run("R6 low", 1, 3'b000, 0, 64'd4, 0, 64'hF000, 0, 2'b10);
    check("R6 low value", {32'd0, result}, 64'h80);
    run("R8 sticky", 1, 3'b000, 0, 64'd1, 0, 64'h0010, 0, 2'b10);
    check("R8 sticky stays", {63'd0, sat_flag}, 64'd1);
  endtask

  task automatic t_clear_priority();
    @(negedge clk);
    instr = mk(0, 3'b000, 0); vec_opnd = 0; wide_src = 64'hFFFF; width_sel = 0;
    in_valid = 1; sat_clr = 1;
    @(negedge clk);
    in_valid = 0; sat_clr = 0; exp_flag = 0;
    check("R8 clear wins", {63'd0, sat_flag}, 64'd0);
  endtask

  task automatic t_illegal();
    logic [31:0] bads [4];
    bads[0] = mk(0, 3'b001, 0);
    bads[1] = mk(0, 3'b000, 0) ^ 32'h0800_0000;
    bads[2] = mk(1, 3'b000, 0) ^ 32'h0000_0001;
    bads[3] = mk(1, 3'b000, 0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      instr = bads[k]; vec_opnd = 0; wide_src = 64'hFFFF_FFFF_FFFF_FFFF;
      width_sel = (k == 3) ? 2'd3 : 2'd0; in_valid = 1;
      @(negedge clk);
      in_valid = 0;
      check("R1 illegal", {63'd0, illegal}, 64'd1);
      check("R1 no valid", {63'd0, out_valid}, 64'd0);
      check("R1 flag untouched", {63'd0, sat_flag}, 64'd0);
    end
  endtask

  initial begin
    #(PERIOD * 100000);
    bad++; total++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_shift_modes();
    t_rounding();
    t_mask();
    t_imm();
    t_saturation();
    t_clear_priority();
    t_illegal();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule